// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits between a parallel byte-write bus and the control logic of a NOR-style flash core. It watches each qualified write cycle (an address and a data byte) and steps a state machine through the multi-cycle unlock sequences that guard destructive operations. Once a sequence completes, it raises a single-cycle request to the program/erase engine. The requests are byte program (with the target address and data latched), whole-chip erase and boot-sector lock enable. It also keeps a flag that tells the read path to return identification codes instead of array data.

Every command opens with the same two-cycle unlock prefix. The third cycle picks the branch. Two branches finish at once: identification on and identification off. One branch arms a program target for the fourth cycle. One branch needs a second unlock prefix and then a sixth cycle that selects erase or lock. When identification mode is active, a lone F0 write also leaves it. Any write that does not fit the current step drops the machine back to idle without issuing anything. While the engine reports busy, writes do not move the machine.

States: `ST_IDLE` (waiting for the prefix), `ST_UNLK1` (first prefix cycle seen), `ST_UNLK2` (prefix complete, awaiting command byte), `ST_PROG_ARM` (next write is the program target), `ST_EXT1` (extended command opened), `ST_EXT2` (second prefix, first cycle seen), `ST_EXT3` (second prefix complete, awaiting erase/lock byte). Transitions on a qualified write:
- `ST_IDLE` goes to `ST_UNLK1` on AA at the first unlock address.
- `ST_UNLK1` goes to `ST_UNLK2` on 55 at the second unlock address.
- `ST_UNLK2` at the first unlock address goes to `ST_PROG_ARM` on A0 and to `ST_EXT1` on 80. On 90 it sets identification mode, and on F0 it clears it; both return to idle.
- `ST_PROG_ARM` issues the program request and returns to idle.
- `ST_EXT1` goes to `ST_EXT2` on AA at the first unlock address.
- `ST_EXT2` goes to `ST_EXT3` on 55 at the second unlock address.
- `ST_EXT3` at the first unlock address issues erase on 10 or lock on 40, then returns to idle.

Every other write returns to `ST_IDLE`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, the state returns to idle. All requests, `id_mode`, `prog_addr` and `prog_data` are 0. A sequence that was partly entered before a reset does not continue after it.
- R2: A write cycle counts only on a rising clock edge where `ce_n`=0, `we_n`=0 and `oe_n`=1. Any other combination is ignored and leaves the sequence state unchanged.
- R3: Only `addr[14:0]` is compared against the unlock addresses 5555h and 2AAAh. Bits 19..15 do not affect matching.
- R4: The writes AA@5555h, 55@2AAAh, A0@5555h, then any fourth write, raise `prog_req` for the one cycle after that fourth write's edge. `prog_addr`/`prog_data` then equal that write's full address and data and hold until the next program request.
- R5: The writes AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 10@5555h raise `erase_req` for one cycle after the sixth edge.
- R6: The same five-cycle opening followed by 40@5555h raises `lock_req` for one cycle after the sixth edge.
- R7: The writes AA@5555h, 55@2AAAh, 90@5555h set `id_mode` after the third edge. The writes AA@5555h, 55@2AAAh, F0@5555h clear it.
- R8: From idle, a single write of F0 to any address clears `id_mode`.
- R9: A write that does not match the expected address and data of the current step returns to idle and issues no request. The following writes must start a new prefix.
- R10: While `busy` is 1, writes are ignored. No request is issued, `id_mode` does not change, and the sequence state is kept.
- R11: At most one of `prog_req`, `erase_req` and `lock_req` is high in any cycle, and each is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| busy | input | 1 | Program/erase engine busy |
| addr | input | 20 | Bus address |
| wdata | input | 8 | Bus write data |
| prog_req | output | 1 | One-cycle byte program request |
| prog_addr | output | 20 | Latched program target address |
| prog_data | output | 8 | Latched program data |
| erase_req | output | 1 | One-cycle chip erase request |
| lock_req | output | 1 | One-cycle boot-sector lock request |
| id_mode | output | 1 | Identification mode active |

## Verification
The checker covers the properties that hold cycle by cycle:
- requests are mutually exclusive and last one cycle;
- busy blocks requests and freezes `id_mode`;
- `id_mode` only moves after a qualified write;
- each request is preceded by the right final byte;
- the program target equals the previous cycle's bus and is otherwise stable.

Whether a request appears after the right number of cycles at all needs the bench's scenarios. The same holds for these behaviours, none of which a single-cycle property can see:
- a malformed step aborts rather than resynchronises;
- a disqualified or busy-time write is skipped without losing the partial sequence;
- high address bits are ignored;
- a reset discards a half-entered command.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PROG_ARM,
        ST_EXT1,
        ST_EXT2,
        ST_EXT3
    } fcd_state_e;

    // Command data bytes; index order matches the decoded flag struct below
    localparam int NUM_CODES = 8;
    localparam logic [7:0] CODE_TABLE [NUM_CODES] = '{
        8'hAA, 8'h55, 8'hA0, 8'h80, 8'h10, 8'h40, 8'h90, 8'hF0
    };

    typedef struct packed {
        logic at_first;
        logic at_second;
        logic d_aa;
        logic d_55;
        logic d_a0;
        logic d_80;
        logic d_10;
        logic d_40;
        logic d_90;
        logic d_f0;
    } cyc_dec_t;

endpackage

// File: rtl/fcd_bus_qual.sv
module fcd_bus_qual (
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic busy,
    output logic wr_ok
);
    // A bus write is taken only with chip and write enabled, output disabled,
    // and no engine operation in flight.
    always_comb begin
        wr_ok = ~ce_n & ~we_n & oe_n & ~busy;
    end
endmodule

// File: rtl/fcd_pattern_match.sv
module fcd_pattern_match
    import fcd_pkg::*;
#(
    parameter int             CMP_W       = 15,
    parameter logic [CMP_W-1:0] FIRST_ADDR  = 15'h5555,
    parameter logic [CMP_W-1:0] SECOND_ADDR = 15'h2AAA
) (
    input  logic [CMP_W-1:0] cmp_addr,
    input  logic [7:0]       wdata,
    output cyc_dec_t         dec
);
    logic [NUM_CODES-1:0] hit;

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        assign hit[i] = (wdata == CODE_TABLE[i]);
    end

    always_comb begin
        dec.at_first  = (cmp_addr == FIRST_ADDR);
        dec.at_second = (cmp_addr == SECOND_ADDR);
        dec.d_aa      = hit[0];
        dec.d_55      = hit[1];
        dec.d_a0      = hit[2];
        dec.d_80      = hit[3];
        dec.d_10      = hit[4];
        dec.d_40      = hit[5];
        dec.d_90      = hit[6];
        dec.d_f0      = hit[7];
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  cyc_dec_t          dec,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req,
    output logic              lock_req,
    output logic              id_mode
);
    fcd_state_e state_q, state_d;
    logic id_d, prog_d, erase_d, lock_d, capture;

    always_comb begin
        state_d = state_q;
        id_d    = id_mode;
        prog_d  = 1'b0;
        erase_d = 1'b0;
        lock_d  = 1'b0;
        capture = 1'b0;
        if (wr_ok) begin
            state_d = ST_IDLE;
            unique case (state_q)
                ST_IDLE: begin
                    if (dec.at_first && dec.d_aa) state_d = ST_UNLK1;
                    else if (dec.d_f0)            id_d    = 1'b0;
                end
                ST_UNLK1: begin
                    if (dec.at_second && dec.d_55) state_d = ST_UNLK2;
                end
                ST_UNLK2: begin
                    if (dec.at_first) begin
                        if (dec.d_a0)      state_d = ST_PROG_ARM;
                        else if (dec.d_80) state_d = ST_EXT1;
                        else if (dec.d_90) id_d    = 1'b1;
                        else if (dec.d_f0) id_d    = 1'b0;
                    end
                end
                ST_PROG_ARM: begin
                    prog_d  = 1'b1;
                    capture = 1'b1;
                end
                ST_EXT1: begin
                    if (dec.at_first && dec.d_aa) state_d = ST_EXT2;
                end
                ST_EXT2: begin
                    if (dec.at_second && dec.d_55) state_d = ST_EXT3;
                end
                ST_EXT3: begin
                    if (dec.at_first) begin
                        if (dec.d_10)      erase_d = 1'b1;
                        else if (dec.d_40) lock_d  = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            lock_req  <= 1'b0;
            id_mode   <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            prog_req  <= prog_d;
            erase_req <= erase_d;
            lock_req  <= lock_d;
            id_mode   <= id_d;
            if (capture) begin
                prog_addr <= addr;
                prog_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int               ADDR_W      = 20,
    parameter int               DATA_W      = 8,
    parameter int               CMP_W       = 15,
    parameter logic [CMP_W-1:0] FIRST_ADDR  = 15'h5555,
    parameter logic [CMP_W-1:0] SECOND_ADDR = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req,
    output logic              lock_req,
    output logic              id_mode
);
    logic     wr_ok;
    cyc_dec_t dec;

    fcd_bus_qual u_qual (
        .ce_n  (ce_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .busy  (busy),
        .wr_ok (wr_ok)
    );

    fcd_pattern_match #(
        .CMP_W       (CMP_W),
        .FIRST_ADDR  (FIRST_ADDR),
        .SECOND_ADDR (SECOND_ADDR)
    ) u_match (
        .cmp_addr (addr[CMP_W-1:0]),
        .wdata    (wdata[7:0]),
        .dec      (dec)
    );

    fcd_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .dec       (dec),
        .addr      (addr),
        .wdata     (wdata),
        .prog_req  (prog_req),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .erase_req (erase_req),
        .lock_req  (lock_req),
        .id_mode   (id_mode)
    );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int               ADDR_W      = 20,
    parameter int               DATA_W      = 8,
    parameter int               CMP_W       = 15,
    parameter logic [CMP_W-1:0] FIRST_ADDR  = 15'h5555
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              busy,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              prog_req,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [DATA_W-1:0] prog_data,
    input logic              erase_req,
    input logic              lock_req,
    input logic              id_mode
);
    a_r11_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, erase_req, lock_req}));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_req || lock_req) |=> !(prog_req || erase_req || lock_req));

    a_r10_busy_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(prog_req || erase_req || lock_req));

    a_r10_busy_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(id_mode));

    a_r2_id_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(id_mode) |-> $past(!ce_n && !we_n && oe_n && !busy));

    a_r4_prog_capture: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (prog_addr == $past(addr) && prog_data == $past(wdata)));

    a_r4_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_req |-> ($stable(prog_addr) && $stable(prog_data)));

    a_r5_erase_byte: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> ($past(wdata[7:0]) == 8'h10 && $past(addr[CMP_W-1:0]) == FIRST_ADDR));

    a_r6_lock_byte: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |-> ($past(wdata[7:0]) == 8'h40 && $past(addr[CMP_W-1:0]) == FIRST_ADDR));
endmodule

bind flash_cmd_decoder fcd_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CMP_W      (CMP_W),
    .FIRST_ADDR (FIRST_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .busy      (busy),
    .addr      (addr),
    .wdata     (wdata),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .erase_req (erase_req),
    .lock_req  (lock_req),
    .id_mode   (id_mode)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
    logic [19:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        prog_req, erase_req, lock_req, id_mode;
    logic [19:0] prog_addr;
    logic [7:0]  prog_data;

    always #2.5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .busy(busy), .addr(addr), .wdata(wdata),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_req(erase_req), .lock_req(lock_req), .id_mode(id_mode)
    );

    typedef struct {
        int          kind;   // 0 program, 1 erase, 2 lock
        logic [19:0] a;
        logic [7:0]  d;
    } exp_t;

    exp_t  expq[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pops an expected item for every request seen
    int   seen_kind;
    exp_t got;
    always @(negedge clk) begin
        if (rst_n && !done && (prog_req || erase_req || lock_req)) begin
            seen_kind = prog_req ? 0 : (erase_req ? 1 : 2);
            chk($countones({prog_req, erase_req, lock_req}) == 1, "R11",
                "requests at once", $countones({prog_req, erase_req, lock_req}), 1);
            if (expq.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected request kind", seen_kind, -1);
            end else begin
                got = expq.pop_front();
                chk(seen_kind == got.kind, cur_tag, "request kind", seen_kind, got.kind);
                if (got.kind == 0) begin
                    chk(prog_addr == got.a, cur_tag, "prog_addr", prog_addr, got.a);
                    chk(prog_data == got.d, cur_tag, "prog_data", prog_data, got.d);
                end
            end
        end
    end

    task automatic bus_cycle(input logic [19:0] a, input logic [7:0] d,
                             input bit ce, input bit we, input bit oe);
        @(negedge clk);
        addr = a; wdata = d; ce_n = ce; we_n = we; oe_n = oe;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        #1;
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        bus_cycle(a, d, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic push(input int k, input logic [19:0] a, input logic [7:0] d);
        exp_t e;
        e.kind = k; e.a = a; e.d = d;
        expq.push_back(e);
    endtask

    task automatic drained(input string tag);
        idle(2);
        chk(expq.size() == 0, tag, "missing requests", expq.size(), 0);
        expq.delete();
    endtask

    task automatic prefix();
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
    endtask

    initial begin
        idle(3);
        // R1: reset state
        chk({prog_req, erase_req, lock_req, id_mode} == 4'b0, "R1", "reset outputs",
            {prog_req, erase_req, lock_req, id_mode}, 0);
        chk(prog_addr == 0 && prog_data == 0, "R1", "reset target", prog_addr, 0);
        rst_n = 1'b1;
        idle(2);

        // R4: program, then target held
        cur_tag = "R4";
        push(0, 20'h12345, 8'h5A);
        prefix(); wr(20'h05555, 8'hA0); wr(20'h12345, 8'h5A);
        idle(1);
        chk(prog_req == 1'b0, "R11", "prog_req second cycle", prog_req, 0);
        drained("R4");
        wr(20'h00010, 8'h33);
        chk(prog_addr == 20'h12345 && prog_data == 8'h5A, "R4", "target held",
            prog_addr, 20'h12345);

        // R3: upper address bits ignored on unlock addresses
        cur_tag = "R3";
        push(0, 20'hFFFFF, 8'h00);
        wr(20'hF5555, 8'hAA); wr(20'h3AAAA, 8'h55); wr(20'h85555, 8'hA0);
        wr(20'hFFFFF, 8'h00);
        drained("R3");

        // R5: chip erase
        cur_tag = "R5";
        push(1, 0, 0);
        prefix(); wr(20'h05555, 8'h80); prefix(); wr(20'h05555, 8'h10);
        drained("R5");

        // R6: lock enable
        cur_tag = "R6";
        push(2, 0, 0);
        prefix(); wr(20'h05555, 8'h80); prefix(); wr(20'h05555, 8'h40);
        drained("R6");

        // R7: identification entry and three-cycle exit
        cur_tag = "R7";
        prefix(); wr(20'h05555, 8'h90);
        chk(id_mode == 1'b1, "R7", "id entry", id_mode, 1);
        prefix(); wr(20'h05555, 8'hF0);
        chk(id_mode == 1'b0, "R7", "id exit", id_mode, 0);

        // R8: single F0 anywhere exits
        cur_tag = "R8";
        prefix(); wr(20'h05555, 8'h90);
        chk(id_mode == 1'b1, "R8", "id re-entry", id_mode, 1);
        wr(20'h00777, 8'hF0);
        chk(id_mode == 1'b0, "R8", "single-write exit", id_mode, 0);

        // R9: mismatches abort without requests
        cur_tag = "R9";
        prefix(); wr(20'h05555, 8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h56);
        wr(20'h05555, 8'h10);
        drained("R9");
        wr(20'h05555, 8'hAA); wr(20'h02AAB, 8'h55); wr(20'h05555, 8'hA0);
        wr(20'h00044, 8'h44);
        drained("R9");
        prefix(); wr(20'h05554, 8'h90);
        chk(id_mode == 1'b0, "R9", "bad address no id", id_mode, 0);
        // after abort the fresh prefix works
        push(0, 20'h00ABC, 8'hC3);
        prefix(); wr(20'h05555, 8'hA0); wr(20'h00ABC, 8'hC3);
        drained("R9");

        // R2: disqualified cycles are skipped, not aborting
        cur_tag = "R2";
        push(0, 20'h00100, 8'h11);
        wr(20'h05555, 8'hAA);
        bus_cycle(20'h00000, 8'h00, 1'b0, 1'b0, 1'b0); // output enable low
        bus_cycle(20'h00000, 8'h00, 1'b1, 1'b0, 1'b1); // chip not enabled
        bus_cycle(20'h00000, 8'h00, 1'b0, 1'b1, 1'b1); // no write strobe
        wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0); wr(20'h00100, 8'h11);
        drained("R2");

        // R10: busy freezes the sequence and the id flag
        cur_tag = "R10";
        push(0, 20'h00200, 8'h22);
        prefix();
        busy = 1'b1;
        wr(20'h05555, 8'h90);
        wr(20'h00999, 8'h99);
        busy = 1'b0;
        chk(id_mode == 1'b0, "R10", "id under busy", id_mode, 0);
        wr(20'h05555, 8'hA0); wr(20'h00200, 8'h22);
        drained("R10");

        // R1: reset discards a partial sequence and clears id mode
        cur_tag = "R1";
        prefix(); wr(20'h05555, 8'h90);
        prefix();
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        chk(id_mode == 1'b0, "R1", "id after reset", id_mode, 0);
        @(negedge clk); rst_n = 1'b1;
        wr(20'h05555, 8'hA0); wr(20'h00300, 8'h77);
        drained("R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule